// File: doc/BRIEF.md
# Dual-Lane Word Serializer with Internal Wrap

This block turns a stream of 10-bit line characters into a serial bit stream. A character is taken in on every rising edge of a word-rate clock and held in a capture register. Once per word it moves into a shift register, which is clocked by a bit clock running at exactly ten times the word rate. The least significant bit leaves first. The characters are expected to be already 8B/10B coded. Encoding, clock synthesis and analog line drivers lie outside this block.

The serial stream is driven onto two lanes that always carry identical data, which allows redundant links. A wrap control sends the stream to an internal tap that feeds the local receiver. While the wrap control is active, both lanes are forced low. The two clocks must be edge-aligned so that a word-clock rising edge coincides with the bit-counter wrap. The shift register reloads at a fixed counter phase in the middle of the word period, so a character is never split across a transfer.

Top module: `ser_dual_tx`

## Requirements
- R1: `tx_word` is sampled only on the rising edge of `word_clk`. A change to `tx_word` between those edges does not alter the character that has already been captured.
- R2: Each character is sent over ten consecutive bit-clock periods, starting with `tx_word[0]` and ending with `tx_word[9]`.
- R3: Code letters map to bits as follows: a=bit0, b=bit1, c=bit2, d=bit3, e=bit4, i=bit5, f=bit6, g=bit7, h=bit8, j=bit9. The line order is therefore a b c d e i f g h j. The comma pattern 0011111010 written in that letter order appears on the line in that order.
- R4: Both lanes of `lane_o` carry the same value in every bit period.
- R5: The shift register reloads once every 10 bit clocks, on the bit edge where the bit counter equals `LOAD_PHASE` (default 4). The counter restarts at 0 after reset. Back-to-back characters therefore leave the block with no gap and no overlap.
- R6: While `lpbk_en` is 1, both lanes are 0 and `wrap_o` carries the serial stream.
- R7: While `lpbk_en` is 0, `wrap_o` is 0.
- R8: The synchronous active-low reset clears the bit counter and the shift register. Both lanes and `wrap_o` stay 0 during reset and until the first reload after release. That reload comes `LOAD_PHASE`+1 bit edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_clk | input | 1 | Word-rate clock; captures `tx_word` on its rising edge |
| bit_clk | input | 1 | Bit clock, ten times the word rate, edge-aligned with `word_clk` |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| tx_word | input | 10 | Coded character; bit 0 goes out first |
| lpbk_en | input | 1 | 1 routes the stream to `wrap_o` and forces the lanes low |
| lane_o | output | 2 | Two identical serial line outputs |
| wrap_o | output | 1 | Internal wrap tap toward the receiver |

## Verification
The assertions take three things for granted about the inputs. First, the bit clock runs at exactly ten times the word clock. Second, a word-clock rising edge lands on the bit edge where the counter wraps to zero, which keeps the reload phase half a word away from the capture edge. Third, reset is held across at least one word-clock edge. The stimulus builds both clocks from one time base with a common first edge. It releases reset one nanosecond after a word edge and changes `tx_word` and `lpbk_en` only at word-clock falling edges, or shortly after a capture edge, never at a capture edge.

// File: rtl/ser_pkg.sv
// Package: shared constants and types for the dual-lane serializer.
// Assumes nothing beyond being compiled before the modules that import it.
package ser_pkg;

    // Bits per coded line character.
    localparam int unsigned CHAR_BITS = 10;

    // Output routing state chosen once per bit period.
    typedef enum logic [1:0] {
        ROUTE_QUIET = 2'd0,   // nothing loaded yet: all outputs low
        ROUTE_LINE  = 2'd1,   // stream on the lanes, tap low
        ROUTE_WRAP  = 2'd2    // stream on the tap, lanes low
    } route_e;

endpackage

// File: rtl/ser_in_latch.sv
// Module: capture register in the word clock domain.
// Samples the parallel character on every rising word-clock edge.
// Assumes rst_n is held low across at least one word-clock edge.
module ser_in_latch #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             word_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Capture the incoming character once per word period.
    always_ff @(posedge word_clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/ser_bit_ctr.sv
// Module: bit-position counter in the bit clock domain.
// Counts 0..RATIO-1 and flags the single phase on which a new word is loaded.
// Assumes word-clock rising edges coincide with the wrap to zero, so the
// load phase sits half a word away from the capture edge.
module ser_bit_ctr #(
    parameter int unsigned RATIO      = 10,
    parameter int unsigned LOAD_PHASE = 4
) (
    input  logic bit_clk,
    input  logic rst_n,
    output logic load_o
);

    localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);
    localparam logic [CNT_W-1:0] PHASE = CNT_W'(LOAD_PHASE);

    logic [CNT_W-1:0] cnt_q;

    // Advance the bit position and wrap after the last bit of a word.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the load phase for the shift register.
    always_comb begin
        load_o = (cnt_q == PHASE);
    end

endmodule

// File: rtl/ser_shifter.sv
// Module: parallel-load, LSB-first shift register.
// Loads on load_i, otherwise shifts right by one per bit clock.
// loaded_o marks that at least one word has been loaded since reset.
module ser_shifter #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o,
    output logic             loaded_o
);

    logic [WIDTH-1:0] sh_q;

    // Load a full word or move the next bit into the output position.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= par_i;
        end else begin
            sh_q <= {1'b0, sh_q[WIDTH-1:1]};
        end
    end

    // Remember that the first word has arrived since reset.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            loaded_o <= 1'b0;
        end else if (load_i) begin
            loaded_o <= 1'b1;
        end
    end

    // Present the current bit.
    always_comb begin
        ser_o = sh_q[0];
    end

endmodule

// File: rtl/ser_out_route.sv
// Module: output routing for the serial stream.
// Sends the stream to every lane or to the wrap tap, and keeps all outputs
// low until the first word is loaded.
module ser_out_route #(
    parameter int unsigned LANES = 2
) (
    input  logic             ser_i,
    input  logic             loaded_i,
    input  logic             wrap_en_i,
    output logic [LANES-1:0] lane_o,
    output logic             wrap_o
);

    import ser_pkg::*;

    route_e route;

    // Pick the routing state for this bit period.
    always_comb begin
        if (!loaded_i) begin
            route = ROUTE_QUIET;
        end else if (wrap_en_i) begin
            route = ROUTE_WRAP;
        end else begin
            route = ROUTE_LINE;
        end
    end

    // Drive each lane from the same stream.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_o[g] = (route == ROUTE_LINE) ? ser_i : 1'b0;
        end
    end

    // Drive the wrap tap.
    always_comb begin
        wrap_o = (route == ROUTE_WRAP) ? ser_i : 1'b0;
    end

endmodule

// File: rtl/ser_dual_tx.sv
// Module: top of the dual-lane serializer with internal wrap.
// Captures a character per word clock, shifts it out LSB first on a bit clock
// running RATIO times faster, and drives two identical lanes or a wrap tap.
// Assumes both clocks come from one source and are edge-aligned so that a
// word edge coincides with the bit-counter wrap.
module ser_dual_tx #(
    parameter int unsigned WORD_W     = ser_pkg::CHAR_BITS,
    parameter int unsigned LANES      = 2,
    parameter int unsigned LOAD_PHASE = 4
) (
    input  logic              word_clk,
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lpbk_en,
    output logic [LANES-1:0]  lane_o,
    output logic              wrap_o
);

    logic [WORD_W-1:0] held_word;
    logic              load_stb;
    logic              ser_bit;
    logic              loaded;

    ser_in_latch #(.WIDTH(WORD_W)) u_latch (
        .word_clk (word_clk),
        .rst_n    (rst_n),
        .d_i      (tx_word),
        .q_o      (held_word)
    );

    ser_bit_ctr #(.RATIO(WORD_W), .LOAD_PHASE(LOAD_PHASE)) u_ctr (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load_o  (load_stb)
    );

    ser_shifter #(.WIDTH(WORD_W)) u_shift (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .load_i   (load_stb),
        .par_i    (held_word),
        .ser_o    (ser_bit),
        .loaded_o (loaded)
    );

    ser_out_route #(.LANES(LANES)) u_route (
        .ser_i     (ser_bit),
        .loaded_i  (loaded),
        .wrap_en_i (lpbk_en),
        .lane_o    (lane_o),
        .wrap_o    (wrap_o)
    );

endmodule

// File: rtl/ser_dual_tx_chk.sv
// Module: property checker for ser_dual_tx, attached with bind.
// Assumes the clock relation and reset length stated for the top module.
module ser_dual_tx_chk #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned LANES  = 2
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             lpbk_en,
    input logic             load_stb,
    input logic             loaded,
    input logic             ser_bit,
    input logic [LANES-1:0] lane_o,
    input logic             wrap_o
);

    localparam int unsigned GAP_W = $clog2(WORD_W) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Count bit clocks since the last load, saturating.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_LANES_AGREE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lane_o == {LANES{lane_o[0]}}); // R4
    AST_LINE_CARRIES: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!lpbk_en && loaded) |-> (lane_o[0] == ser_bit)); // R2
    AST_WRAP_SILENCES_LINE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        lpbk_en |-> (lane_o == '0)); // R6
    AST_WRAP_CARRIES: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (lpbk_en && loaded) |-> (wrap_o == ser_bit)); // R6
    AST_TAP_IDLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !lpbk_en |-> !wrap_o); // R7
    AST_QUIET_UNTIL_LOAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !loaded |-> (lane_o == '0 && !wrap_o)); // R8
    AST_LOAD_SPACING: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (load_stb && seen_q) |-> (gap_q == GAP_W'(WORD_W - 1))); // R5

endmodule

bind ser_dual_tx ser_dual_tx_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .lpbk_en  (lpbk_en),
    .load_stb (load_stb),
    .loaded   (loaded),
    .ser_bit  (ser_bit),
    .lane_o   (lane_o),
    .wrap_o   (wrap_o)
);

// File: tb/tb_ser_dual_tx.sv
`timescale 1ns/1ps
// Bench: directed scenarios for ser_dual_tx, one task each.
// Bit clock 200 MHz; word clock at one tenth, sharing the first rising edge.
module tb_ser_dual_tx;

    logic       bit_clk  = 1'b0;
    logic       word_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic [9:0] tx_word  = '0;
    logic       lpbk_en  = 1'b0;
    logic [1:0] lane_o;
    logic       wrap_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ser_dual_tx dut (
        .word_clk (word_clk),
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .tx_word  (tx_word),
        .lpbk_en  (lpbk_en),
        .lane_o   (lane_o),
        .wrap_o   (wrap_o)
    );

    // Bit clock, 5 ns period.
    always #2.5 bit_clk = ~bit_clk;

    // Word clock, 50 ns period, rising together with the first bit edge.
    initial begin
        #2.5;
        forever begin
            word_clk = 1'b1;
            #25;
            word_clk = 1'b0;
            #25;
        end
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Check one bit period: lanes or tap carry exp according to lb.
    task automatic chk_bit(input logic exp, input logic lb, input string req);
        if (lb) begin
            chk(lane_o[0], 1'b0, req, "lane0 low in wrap");
            chk(lane_o[1], 1'b0, req, "lane1 low in wrap");
            chk(wrap_o, exp, req, "wrap tap bit");
        end else begin
            chk(lane_o[0], exp, req, "lane0 bit");
            chk(lane_o[1], exp, req, "lane1 bit");
            chk(wrap_o, 1'b0, req, "wrap tap idle");
        end
    endtask

    // R8: reset quiets outputs until the first reload after release.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge word_clk);
        @(negedge bit_clk);
        chk(lane_o[0], 1'b0, "R8", "lane0 in reset");
        chk(lane_o[1], 1'b0, "R8", "lane1 in reset");
        chk(wrap_o, 1'b0, "R8", "tap in reset");
        @(posedge word_clk);
        #1 rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge bit_clk);
            chk(lane_o[0], 1'b0, "R8", "lane0 before first load");
            chk(lane_o[1], 1'b0, "R8", "lane1 before first load");
        end
    endtask

    // R2/R4/R6/R7: send one word and check its ten bits LSB first.
    task automatic t_word(input logic [9:0] w, input logic lb, input string req);
        @(negedge word_clk);
        tx_word = w;
        lpbk_en = lb;
        @(posedge word_clk);
        #1;
        repeat (5) @(posedge bit_clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge bit_clk);
            chk_bit(w[k], lb, req);
        end
    endtask

    // R1/R5: two back-to-back words; input changes right after capture.
    task automatic t_stream(input logic [9:0] w0, input logic [9:0] w1);
        @(negedge word_clk);
        tx_word = w0;
        lpbk_en = 1'b0;
        @(posedge word_clk);
        #1 tx_word = w1;
        repeat (5) @(posedge bit_clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge bit_clk);
            chk_bit(w0[k], 1'b0, "R1");
        end
        for (int k = 0; k < 10; k++) begin
            @(negedge bit_clk);
            chk_bit(w1[k], 1'b0, "R5");
        end
    endtask

    // R3: comma in letter order a b c d e i f g h j = 0011111010.
    task automatic t_letters();
        logic [9:0] seq;
        logic [9:0] w;
        seq = 10'b0011111010;   // seq[9] is letter a, seq[0] is letter j
        for (int k = 0; k < 10; k++) begin
            w[k] = seq[9-k];
        end
        t_word(w, 1'b0, "R3");
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge bit_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_letters();
        t_word(10'b0000000001, 1'b0, "R2");
        t_word(10'b1000000000, 1'b0, "R2");
        t_word(10'h3FF, 1'b0, "R4");
        t_word(10'h2AA, 1'b0, "R4");
        t_stream(10'h155, 10'h0F3);
        t_word(10'h1A5, 1'b1, "R6");
        t_word(10'h0C7, 1'b1, "R6");
        t_word(10'h36B, 1'b0, "R7");
        tx_word = 10'h3FF;
        t_reset();
        t_word(10'h21C, 1'b0, "R8");
        done = 1'b1;
        report();
        $finish;
    end

endmodule